// File: doc/BRIEF.md
# Microcoded 8-bit Accumulator Processor

This block is a small multi-cycle processor. One 8-bit internal bus links all of its registers and its memory. Code and data share a 16-byte RAM. Each byte in the RAM is one instruction. The upper nibble of the byte is the opcode and the lower nibble is the operand. The operand is either a RAM address or a 4-bit immediate value.

A step counter runs every instruction through five steps. The first two steps fetch the instruction. The last three execute it. At each step a control word, decoded from the step number, the opcode and the flags, selects which unit drives the bus and which units load from it.

To use the block, hold reset low and write the program into RAM through the load port. Then release reset and pulse the step enable: tie it high to run at full speed, or toggle it to single-step. Results appear on the output register together with a one-cycle valid strobe. The halted flag goes high once a halt instruction has executed.

Top module: `acc_cpu`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `out_value` is 0x00 and `out_valid` and `halted` are 0. Reset clears the program counter, the accumulator, both flags and the step counter, so execution starts at address 0 with A = 0x00. Reset leaves RAM unchanged.
- R2: A rising clock edge with `rst_n` low and `load_we` high writes `load_data` into RAM at `load_addr`. While `rst_n` is high, the load port has no effect.
- R3: Every instruction takes exactly five enabled clock edges. The instruction byte has the opcode in bits 7:4 and the operand in bits 3:0. When an OUT instruction is at address k of a straight-line program, its result appears after enabled edge 5k+3, and `out_valid` is high for the cycle after that edge.
- R4: A clock edge with `step_en` low changes no state. Gaps in `step_en` do not change results or enabled-edge counts.
- R5: LDA (0x1) copies RAM[operand] into A. LDI (0x5) loads A with the operand, zero-extended to 8 bits.
- R6: ADD (0x2) sets A to (A + RAM[operand]) mod 256. Carry is set when the true sum exceeds 255. Zero is set when the 8-bit result is 0x00.
- R7: SUB (0x3) computes A + ~RAM[operand] + 1. A gets the 8-bit result. Carry is set when A >= RAM[operand] (no borrow). Zero is set when the result is 0x00.
- R8: STA (0x4) writes A into RAM[operand].
- R9: JMP (0x6) always loads the program counter with the operand. JC (0x7) loads it only when carry is set. JZ (0x8) loads it only when zero is set.
- R10: Only ADD and SUB change the carry and zero flags.
- R11: OUT (0xE) copies A into the output register and pulses `out_valid` for one cycle. At all other times the output register holds its value.
- R12: HLT (0xF) sets `halted`, which then stays set until reset. While `halted` is set, no further instruction executes, whatever `step_en` does.
- R13: NOP (0x0) and the unassigned opcodes 0x9 to 0xD change nothing except advancing the program counter.
- R14: The program counter is 4 bits wide and wraps from 15 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset; the load port works only while this is low |
| step_en | input | 1 | Advances the processor by one step per edge while high |
| load_we | input | 1 | Write strobe of the program-load port |
| load_addr | input | 4 | RAM address of the program-load write |
| load_data | input | 8 | Byte written by the program-load port |
| out_value | output | 8 | Output register |
| out_valid | output | 1 | High for one cycle after the output register is loaded |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The assertions take for granted that the load port is used only during reset. They also take for granted that `step_en` is the only source of progress, so a register that is not loaded, or a halted machine, must hold still. The stimulus keeps to this rule: it writes every program under reset and starts execution only after reset is released. One test drives the load port on purpose while the processor runs, to show that the writes are dropped. Arithmetic is swept over a grid of operand pairs, plus the pairs that wrap to zero. The bench predicts sum, carry and zero from integer arithmetic, and the program itself reports the flags through conditional jumps.

// File: rtl/acc_cpu_pkg.sv
// Shared widths, opcode values, step numbers and the control word layout
// for the accumulator processor. Assumes an 8-bit instruction split into
// a 4-bit opcode and a 4-bit operand.
package acc_cpu_pkg;

    localparam int DATA_W = 8;
    localparam int OPC_W  = 4;
    localparam int ADDR_W = DATA_W - OPC_W;
    localparam int STEPS  = 5;
    localparam int STEP_W = $clog2(STEPS);

    localparam logic [OPC_W-1:0] OP_NOP = 4'h0;
    localparam logic [OPC_W-1:0] OP_LDA = 4'h1;
    localparam logic [OPC_W-1:0] OP_ADD = 4'h2;
    localparam logic [OPC_W-1:0] OP_SUB = 4'h3;
    localparam logic [OPC_W-1:0] OP_STA = 4'h4;
    localparam logic [OPC_W-1:0] OP_LDI = 4'h5;
    localparam logic [OPC_W-1:0] OP_JMP = 4'h6;
    localparam logic [OPC_W-1:0] OP_JC  = 4'h7;
    localparam logic [OPC_W-1:0] OP_JZ  = 4'h8;
    localparam logic [OPC_W-1:0] OP_OUT = 4'hE;
    localparam logic [OPC_W-1:0] OP_HLT = 4'hF;

    localparam logic [STEP_W-1:0] ST_ADDR  = STEP_W'(0);
    localparam logic [STEP_W-1:0] ST_FETCH = STEP_W'(1);
    localparam logic [STEP_W-1:0] ST_EX1   = STEP_W'(2);
    localparam logic [STEP_W-1:0] ST_EX2   = STEP_W'(3);
    localparam logic [STEP_W-1:0] ST_EX3   = STEP_W'(4);

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_PC   = 3'd1,
        SRC_RAM  = 3'd2,
        SRC_OPND = 3'd3,
        SRC_ACC  = 3'd4,
        SRC_ALU  = 3'd5
    } bus_src_e;

    typedef struct packed {
        bus_src_e src;
        logic     ld_mar;
        logic     ld_ir;
        logic     ld_acc;
        logic     ld_opb;
        logic     ld_out;
        logic     ram_we;
        logic     pc_inc;
        logic     pc_ld;
        logic     alu_sub;
        logic     flag_we;
        logic     halt;
    } ctrl_word_t;

endpackage

// File: rtl/acc_cpu_reg.sv
// Loadable register with synchronous active-low reset to zero.
// Assumes load is already qualified by the step enable.
module acc_cpu_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Capture d only on a qualified load; otherwise keep the stored value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end

    AST_HOLD_UNLOADED: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q)); // R11

endmodule

// File: rtl/acc_cpu_ram.sv
// Unified code/data memory with combinational read. Two write ports:
// the processor port and the program-load port. The load port wins
// when both fire. Contents are not reset. Assumes the caller gates the
// load port with reset.
module acc_cpu_ram #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Write from the load port or the processor port.
    always_ff @(posedge clk) begin
        if (ld_we)
            mem[ld_addr] <= ld_wdata;
        else if (cpu_we)
            mem[cpu_addr] <= cpu_wdata;
    end

    // Read the addressed byte without delay.
    always_comb rdata = mem[cpu_addr];

    AST_SINGLE_WRITER: assert property (@(posedge clk)
        !(ld_we && cpu_we)); // R2

endmodule

// File: rtl/acc_cpu_alu.sv
// Adder/subtractor. Subtraction is a + ~b + 1, so carry-out set means
// no borrow. Zero reflects the W-bit result. Purely combinational.
module acc_cpu_alu #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         carry,
    output logic         zero
);

    logic [W-1:0] b_eff;

    // Invert the second operand for subtraction.
    always_comb b_eff = b ^ {W{sub}};

    // Wide add with carry-in from the subtract select.
    always_comb {carry, res} = {1'b0, a} + {1'b0, b_eff} + (W+1)'(sub);

    // Flag an all-zero result.
    always_comb zero = (res == '0);

endmodule

// File: rtl/acc_cpu_seq.sv
// Step-counter control unit. It sequences five steps per instruction and
// decodes a control word from the step, the opcode and the flags. It also
// holds the halt state. Assumes the flags given are the registered ones.
module acc_cpu_seq
    import acc_cpu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic [OPC_W-1:0] opcode,
    input  logic             carry_f,
    input  logic             zero_f,
    output ctrl_word_t       cw,
    output logic             advance,
    output logic             halted
);

    logic [STEP_W-1:0] step;

    // Progress needs reset released, an enable, and no halt.
    always_comb advance = rst_n && step_en && !halted;

    // Count steps 0..STEPS-1, restarting after the last.
    always_ff @(posedge clk) begin
        if (!rst_n)
            step <= ST_ADDR;
        else if (advance)
            step <= (step == ST_EX3) ? ST_ADDR : step + STEP_W'(1);
    end

    // Latch halt when the halt step is executed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            halted <= 1'b0;
        else if (advance && cw.halt)
            halted <= 1'b1;
    end

    // Decode the control word for the current step.
    always_comb begin
        cw = ctrl_word_t'(0);
        case (step)
            ST_ADDR: begin
                cw.src    = SRC_PC;
                cw.ld_mar = 1'b1;
            end
            ST_FETCH: begin
                cw.src    = SRC_RAM;
                cw.ld_ir  = 1'b1;
                cw.pc_inc = 1'b1;
            end
            ST_EX1: begin
                case (opcode)
                    OP_LDA, OP_ADD, OP_SUB, OP_STA: begin
                        cw.src    = SRC_OPND;
                        cw.ld_mar = 1'b1;
                    end
                    OP_LDI: begin
                        cw.src    = SRC_OPND;
                        cw.ld_acc = 1'b1;
                    end
                    OP_JMP: begin
                        cw.src   = SRC_OPND;
                        cw.pc_ld = 1'b1;
                    end
                    OP_JC: begin
                        cw.src   = SRC_OPND;
                        cw.pc_ld = carry_f;
                    end
                    OP_JZ: begin
                        cw.src   = SRC_OPND;
                        cw.pc_ld = zero_f;
                    end
                    OP_OUT: begin
                        cw.src    = SRC_ACC;
                        cw.ld_out = 1'b1;
                    end
                    OP_HLT: cw.halt = 1'b1;
                    default: ;
                endcase
            end
            ST_EX2: begin
                case (opcode)
                    OP_LDA: begin
                        cw.src    = SRC_RAM;
                        cw.ld_acc = 1'b1;
                    end
                    OP_ADD, OP_SUB: begin
                        cw.src    = SRC_RAM;
                        cw.ld_opb = 1'b1;
                    end
                    OP_STA: begin
                        cw.src    = SRC_ACC;
                        cw.ram_we = 1'b1;
                    end
                    default: ;
                endcase
            end
            ST_EX3: begin
                if (opcode == OP_ADD || opcode == OP_SUB) begin
                    cw.src     = SRC_ALU;
                    cw.ld_acc  = 1'b1;
                    cw.flag_we = 1'b1;
                    cw.alu_sub = (opcode == OP_SUB);
                end
            end
            default: ;
        endcase
    end

    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        step < STEP_W'(STEPS)); // R3

    AST_STEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(step)); // R4

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R12

endmodule

// File: rtl/acc_cpu.sv
// Top level of the accumulator processor. It builds the shared bus
// multiplexer, the program counter, the flags and the output strobe, and
// wires up the registers, RAM, ALU and control unit. Assumes programs are
// loaded only while reset is held low.
module acc_cpu
    import acc_cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              load_we,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    output logic [DATA_W-1:0] out_value,
    output logic              out_valid,
    output logic              halted
);

    ctrl_word_t        cw;
    logic              advance;
    logic [DATA_W-1:0] bus;
    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] mar;
    logic [DATA_W-1:0] ir;
    logic [DATA_W-1:0] acc;
    logic [DATA_W-1:0] opb;
    logic [DATA_W-1:0] ram_rdata;
    logic [DATA_W-1:0] alu_res;
    logic              alu_c;
    logic              alu_z;
    logic              carry_q;
    logic              zero_q;

    acc_cpu_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (step_en),
        .opcode  (ir[DATA_W-1:ADDR_W]),
        .carry_f (carry_q),
        .zero_f  (zero_q),
        .cw      (cw),
        .advance (advance),
        .halted  (halted)
    );

    // Select the single driver of the shared bus.
    always_comb begin
        case (cw.src)
            SRC_PC:   bus = DATA_W'(pc);
            SRC_RAM:  bus = ram_rdata;
            SRC_OPND: bus = DATA_W'(ir[ADDR_W-1:0]);
            SRC_ACC:  bus = acc;
            SRC_ALU:  bus = alu_res;
            default:  bus = '0;
        endcase
    end

    acc_cpu_reg #(.W(ADDR_W)) u_mar (
        .clk(clk), .rst_n(rst_n), .load(advance && cw.ld_mar),
        .d(bus[ADDR_W-1:0]), .q(mar)
    );

    acc_cpu_reg #(.W(DATA_W)) u_ir (
        .clk(clk), .rst_n(rst_n), .load(advance && cw.ld_ir),
        .d(bus), .q(ir)
    );

    acc_cpu_reg #(.W(DATA_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .load(advance && cw.ld_acc),
        .d(bus), .q(acc)
    );

    acc_cpu_reg #(.W(DATA_W)) u_opb (
        .clk(clk), .rst_n(rst_n), .load(advance && cw.ld_opb),
        .d(bus), .q(opb)
    );

    acc_cpu_reg #(.W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n), .load(advance && cw.ld_out),
        .d(bus), .q(out_value)
    );

    acc_cpu_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
        .clk       (clk),
        .cpu_we    (advance && cw.ram_we),
        .cpu_addr  (mar),
        .cpu_wdata (bus),
        .ld_we     (!rst_n && load_we),
        .ld_addr   (load_addr),
        .ld_wdata  (load_data),
        .rdata     (ram_rdata)
    );

    acc_cpu_alu #(.W(DATA_W)) u_alu (
        .a     (acc),
        .b     (opb),
        .sub   (cw.alu_sub),
        .res   (alu_res),
        .carry (alu_c),
        .zero  (alu_z)
    );

    // Program counter: a jump load wins over the fetch increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= '0;
        else if (advance && cw.pc_ld)
            pc <= bus[ADDR_W-1:0];
        else if (advance && cw.pc_inc)
            pc <= pc + ADDR_W'(1);
    end

    // Flags update only on the arithmetic write-back step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
            zero_q  <= 1'b0;
        end else if (advance && cw.flag_we) begin
            carry_q <= alu_c;
            zero_q  <= alu_z;
        end
    end

    // One-cycle strobe following an output-register load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else
            out_valid <= advance && cw.ld_out;
    end

    AST_FLAGS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(advance && cw.flag_we) |=> $stable(carry_q) && $stable(zero_q)); // R10

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R11

    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(pc) && $stable(acc) && $stable(out_value)); // R12

    AST_PC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && cw.pc_inc && !cw.pc_ld && pc == '1) |=> pc == '0); // R14

endmodule

// File: tb/tb_acc_cpu.sv
module tb_acc_cpu;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_en = 1'b0;
    logic       load_we = 1'b0;
    logic [3:0] load_addr = '0;
    logic [7:0] load_data = '0;
    logic [7:0] out_value;
    logic       out_valid;
    logic       halted;

    acc_cpu dut (
        .clk(clk), .rst_n(rst_n), .step_en(step_en),
        .load_we(load_we), .load_addr(load_addr), .load_data(load_data),
        .out_value(out_value), .out_valid(out_valid), .halted(halted)
    );

    always #10 clk = ~clk;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [7:0] img [16];
    int outs [8];
    int out_edge [8];
    int n_out;
    int halt_edge;

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        wait (cyc >= 190000);
        bad = bad + 1;
        total = total + 1;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ins(input logic [3:0] op, input logic [3:0] arg);
        return {op, arg};
    endfunction

    function automatic void clear_img();
        for (int i = 0; i < 16; i++) img[i] = 8'h00;
    endfunction

    // Load img under reset, check the reset outputs, then release reset.
    task automatic load_image();
        @(negedge clk);
        rst_n = 1'b0;
        step_en = 1'b0;
        for (int i = 0; i < 16; i++) begin
            load_we = 1'b1;
            load_addr = 4'(i);
            load_data = img[i];
            @(negedge clk);
        end
        load_we = 1'b0;
        @(negedge clk);
        chk(out_value == 8'h00 && !out_valid && !halted, "R1 reset outputs",
            {out_value, out_valid, halted}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_value == 8'h00 && !out_valid && !halted, "R1 after release",
            {out_value, out_valid, halted}, 0);
    endtask

    // Run, recording outputs and enabled-edge counts.
    task automatic run_prog(input int max_cyc, input bit gappy, input bit intrude);
        int en_edges = 0;
        int post = 0;
        n_out = 0;
        halt_edge = -1;
        for (int c = 0; c < max_cyc; c++) begin
            step_en = gappy ? ((c % 3) != 1) : 1'b1;
            if (intrude) begin
                load_we = 1'b1;
                load_addr = 4'hF;
                load_data = 8'hCC;
            end
            @(posedge clk);
            if (step_en) en_edges++;
            @(negedge clk);
            if (out_valid) begin
                if (n_out < 8) begin
                    outs[n_out] = int'(out_value);
                    out_edge[n_out] = en_edges;
                end
                n_out++;
            end
            if (halted && halt_edge < 0) halt_edge = en_edges;
            if (halt_edge >= 0) post++;
            if (post > 20) break;
        end
        load_we = 1'b0;
        step_en = 1'b0;
    endtask

    // Arithmetic sweep case: outputs result, carry and zero.
    task automatic arith_case(input bit sub, input int a, input int b);
        int full;
        int exp_res;
        int exp_c;
        int exp_z;
        clear_img();
        img[0]  = ins(4'h1, 4'd14);
        img[1]  = ins(sub ? 4'h3 : 4'h2, 4'd15);
        img[2]  = ins(4'hE, 4'd0);
        img[3]  = ins(4'h7, 4'd6);
        img[4]  = ins(4'h5, 4'd0);
        img[5]  = ins(4'h6, 4'd7);
        img[6]  = ins(4'h5, 4'd1);
        img[7]  = ins(4'hE, 4'd0);
        img[8]  = ins(4'h8, 4'd11);
        img[9]  = ins(4'h5, 4'd0);
        img[10] = ins(4'h6, 4'd12);
        img[11] = ins(4'h5, 4'd1);
        img[12] = ins(4'hE, 4'd0);
        img[13] = ins(4'hF, 4'd0);
        img[14] = 8'(a);
        img[15] = 8'(b);
        load_image();
        run_prog(150, 1'b0, 1'b0);
        if (sub) begin
            full = a + (255 - b) + 1;
        end else begin
            full = a + b;
        end
        exp_res = full % 256;
        exp_c = (full > 255) ? 1 : 0;
        exp_z = (exp_res == 0) ? 1 : 0;
        chk(n_out == 3, sub ? "R7 output count" : "R6 output count", n_out, 3);
        if (n_out == 3) begin
            chk(outs[0] == exp_res, sub ? "R7 result" : "R6 result", outs[0], exp_res);
            chk(outs[1] == exp_c, sub ? "R7 R9 carry via JC" : "R6 R9 carry via JC", outs[1], exp_c);
            chk(outs[2] == exp_z, sub ? "R7 R9 R10 zero via JZ" : "R6 R9 R10 zero via JZ",
                outs[2], exp_z);
        end
    endtask

    initial begin
        // R1 R3 R5 R11 R12: straight-line program with exact timing.
        clear_img();
        img[0] = ins(4'hE, 4'd0);
        img[1] = ins(4'h5, 4'd9);
        img[2] = ins(4'hE, 4'd0);
        img[3] = ins(4'hF, 4'd0);
        load_image();
        run_prog(100, 1'b0, 1'b0);
        chk(n_out == 2, "R12 no output after halt", n_out, 2);
        chk(outs[0] == 0, "R1 A cleared", outs[0], 0);
        chk(out_edge[0] == 3, "R3 first OUT edge", out_edge[0], 3);
        chk(outs[1] == 9, "R5 LDI value", outs[1], 9);
        chk(out_edge[1] == 13, "R3 second OUT edge", out_edge[1], 13);
        chk(halt_edge == 18, "R12 halt edge", halt_edge, 18);
        chk(out_value == 8'd9, "R11 output held", int'(out_value), 9);
        chk(halted == 1'b1, "R12 halted stays", int'(halted), 1);

        // R4: same program with gaps in step_en.
        load_image();
        run_prog(200, 1'b1, 1'b0);
        chk(n_out == 2 && outs[1] == 9, "R4 gapped result", outs[1], 9);
        chk(out_edge[1] == 13, "R4 gapped edge count", out_edge[1], 13);
        chk(halt_edge == 18, "R4 gapped halt edge", halt_edge, 18);

        // R6 R7 R9 R10: arithmetic sweep with flags reported by jumps.
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                arith_case(1'b0, i * 17, j * 17);
                arith_case(1'b1, i * 17, j * 17);
            end
        end
        arith_case(1'b0, 1, 255);
        arith_case(1'b0, 128, 128);
        arith_case(1'b1, 0, 1);
        arith_case(1'b1, 200, 199);

        // R1 R10: flags are clear after reset (last run left carry set).
        arith_case(1'b0, 255, 1);
        clear_img();
        img[0] = ins(4'h7, 4'd5);
        img[1] = ins(4'h8, 4'd5);
        img[2] = ins(4'h5, 4'd7);
        img[3] = ins(4'hE, 4'd0);
        img[4] = ins(4'hF, 4'd0);
        img[5] = ins(4'h5, 4'd2);
        img[6] = ins(4'hE, 4'd0);
        img[7] = ins(4'hF, 4'd0);
        load_image();
        run_prog(100, 1'b0, 1'b0);
        chk(n_out == 1 && outs[0] == 7, "R10 flags cleared by reset", outs[0], 7);

        // R8 R5: store then load back.
        clear_img();
        img[0]  = ins(4'h5, 4'd7);
        img[1]  = ins(4'h4, 4'd15);
        img[2]  = ins(4'h5, 4'd0);
        img[3]  = ins(4'h1, 4'd15);
        img[4]  = ins(4'hE, 4'd0);
        img[5]  = ins(4'hF, 4'd0);
        img[15] = 8'h3C;
        load_image();
        run_prog(100, 1'b0, 1'b0);
        chk(n_out == 1 && outs[0] == 7, "R8 store and reload", outs[0], 7);

        // R2: load port ignored while running.
        clear_img();
        img[0]  = ins(4'h1, 4'd15);
        img[1]  = ins(4'hE, 4'd0);
        img[2]  = ins(4'hF, 4'd0);
        img[15] = 8'hA5;
        load_image();
        run_prog(100, 1'b0, 1'b1);
        chk(n_out == 1 && outs[0] == 8'hA5, "R2 load ignored when running", outs[0], 8'hA5);

        // R9: unconditional jump skips code.
        clear_img();
        img[0] = ins(4'h6, 4'd3);
        img[1] = ins(4'h5, 4'd1);
        img[2] = ins(4'hE, 4'd0);
        img[3] = ins(4'h5, 4'd2);
        img[4] = ins(4'hE, 4'd0);
        img[5] = ins(4'hF, 4'd0);
        load_image();
        run_prog(100, 1'b0, 1'b0);
        chk(n_out == 1 && outs[0] == 2, "R9 JMP taken", outs[0], 2);

        // R13: NOP and unassigned opcodes.
        for (int k = 0; k < 16; k++) begin
            if (k == 0 || (k >= 9 && k <= 13)) begin
                clear_img();
                img[0] = ins(4'h5, 4'd3);
                img[1] = ins(4'(k), 4'd5);
                img[2] = ins(4'hE, 4'd0);
                img[3] = ins(4'hF, 4'd0);
                load_image();
                run_prog(100, 1'b0, 1'b0);
                chk(n_out == 1 && outs[0] == 3, "R13 no-op value", outs[0], 3);
                chk(out_edge[0] == 13, "R13 no-op timing", out_edge[0], 13);
            end
        end

        // R14: program counter wraps from 15 to 0.
        clear_img();
        img[0]  = ins(4'hE, 4'd0);
        img[1]  = ins(4'h6, 4'd13);
        img[13] = ins(4'h5, 4'd6);
        load_image();
        run_prog(40, 1'b0, 1'b0);
        chk(n_out >= 2, "R14 wrap output count", n_out, 2);
        chk(outs[1] == 6, "R14 wrap value", outs[1], 6);
        chk(out_edge[1] == 28, "R14 wrap edge", out_edge[1], 28);
        chk(halted == 1'b0, "R14 not halted", int'(halted), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule